// File: doc/BRIEF.md
# Sectored Four-Way Tag Bank with Deferred Dirty Array

This block is the tag store for one interleaved bank of a four-way set-associative, sectored second-level cache. Every set holds four way records. Each record carries a 20-bit address tag, 4 virtual-synonym bits and an 8-bit state byte. A processor-side lookup port compares the presented tag against all four ways of the addressed set. One cycle later it returns whether a tag matched, the matching way as a 2-bit number, the stored synonym bits and state, whether the synonym also matched, and the dirty status of the addressed sector.

Dirty status is kept in a separate array with one bit per sector per way, 16 bits per set. That array is consulted in the cycle after the tag compare. When a write lookup hits a clean sector of an exclusive line, the dirty bit is set one clock later, while the tag array already serves the next lookup. A lookup that arrives while that update is still pending sees the update through forwarding. When a write lookup hits a sector that is already dirty, the result carries a write-back request for the cache controller.

The cache controller owns a second port. It writes either the tag or the state-and-synonym fields of one way, sharing one 20-bit bus between the two. It can also read back a full way record together with that way's four sector dirty bits. The set count is a parameter: the full-size bank uses 8192 sets (IDX_W = 13), and the default is a smaller build.

Top module: `l2_tag_bank`

## Requirements
- R1: After reset every way is invalid and every dirty bit is clear, so the first lookup to any set reports no tag match and no hit, and neither result-valid output is asserted while reset is held.
- R2: A lookup presented with lk_valid produces exactly one result on the next cycle with rs_valid high. On a match, rs_way gives the way number (0 to 3) and rs_syn/rs_state give that way's stored fields. On a miss, rs_way, rs_syn and rs_state are zero.
- R3: A way whose state bits [1:0] are 00 (invalid) never reports a tag match, even when its tag equals the lookup tag. Codes 01 (shared), 10 (exclusive) and 11 count as valid.
- R4: rs_tag_match reports a tag match on a valid way. rs_hit additionally requires the stored synonym bits to equal lk_syn. A write whose synonym mismatches changes no dirty bit.
- R5: A write lookup (lk_write=1) that hits a clean sector of a way in exclusive state (10) reports rs_dirty=0 and sets the dirty bit of that way and sector. Later lookups of that sector report rs_dirty=1, and other sectors keep their own status.
- R6: A write hit on a way in shared state (01) sets no dirty bit.
- R7: A write hit on a sector whose dirty bit is set asserts rs_wb_req with that result, and the bit stays set. Read lookups never assert rs_wb_req.
- R8: A lookup issued in the cycle right after a write hit that set a dirty bit sees the new dirty bit.
- R9: A controller write with cc_wr_sel=0 replaces only the tag of the selected way with cc_bus. With cc_wr_sel=1 it replaces only the synonym bits (from cc_bus[11:8]) and the state byte (from cc_bus[7:0]), and clears that way's four sector dirty bits.
- R10: A controller read (cc_rd_en) returns cc_rd_valid one cycle later. cc_rd_rec is {tag[31:12], synonym[11:8], state[7:0]}, and cc_rd_dirty bit s is the dirty bit of sector s of that way.
- R11: When several valid ways of a set carry the lookup tag, the lowest-numbered way is reported.
- R12: Lookups with lk_write=0 never change any dirty bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_write | input | 1 | Lookup is for a store |
| lk_index | input | IDX_W | Set index of the lookup |
| lk_sector | input | 2 | Sector within the line |
| lk_tag | input | 20 | Address tag to compare |
| lk_syn | input | 4 | Expected virtual-synonym bits |
| rs_valid | output | 1 | Lookup result present |
| rs_tag_match | output | 1 | A valid way carries the tag |
| rs_hit | output | 1 | Tag and synonym both match |
| rs_way | output | 2 | Encoded matching way |
| rs_syn | output | 4 | Stored synonym bits of matching way |
| rs_state | output | 8 | Stored state byte of matching way |
| rs_dirty | output | 1 | Dirty bit of addressed sector on a hit |
| rs_wb_req | output | 1 | Write hit on dirty sector, write-back needed |
| cc_wr_en | input | 1 | Controller write strobe |
| cc_wr_sel | input | 1 | 0 writes tag, 1 writes synonym and state |
| cc_rd_en | input | 1 | Controller read strobe |
| cc_index | input | IDX_W | Controller set index |
| cc_way | input | 2 | Controller way select |
| cc_bus | input | 20 | Shared tag / synonym-and-state write bus |
| cc_rd_valid | output | 1 | Controller read data present |
| cc_rd_rec | output | 32 | Way record read back |
| cc_rd_dirty | output | 4 | Sector dirty bits of that way |

## Verification
Lookups are run against sets prepared so that each outcome can be told apart from the others. These include a plain miss, a tag equal on an invalid way, a tag match with a wrong synonym, a full hit, and the same tag in two valid ways. Store lookups are aimed at exclusive and at shared lines. Back-to-back stores to one sector separate the forwarded dirty path from the committed one, and a later store after a gap checks the array itself. Controller reads after tag-only and state-only writes show which fields each write mode touched and that a state write clears the way's dirty bits.

// File: rtl/l2tag_pkg.sv
package l2tag_pkg;

    localparam int TAG_W   = 20;
    localparam int SYN_W   = 4;
    localparam int ST_W    = 8;
    localparam int WAYS    = 4;
    localparam int SECTORS = 4;
    localparam int WAY_W   = $clog2(WAYS);
    localparam int SEC_W   = $clog2(SECTORS);
    localparam int REC_W   = TAG_W + SYN_W + ST_W;
    localparam int DIRTY_W = WAYS * SECTORS;
    localparam int DPOS_W  = $clog2(DIRTY_W);

    // Coherence code held in state bits [1:0]
    typedef enum logic [1:0] {
        LS_INVALID = 2'b00,
        LS_SHARED  = 2'b01,
        LS_EXCL    = 2'b10,
        LS_OTHER   = 2'b11
    } line_state_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [SYN_W-1:0] syn;
        logic [ST_W-1:0]  st;
    } way_rec_t;

    // Lookup captured after the tag compare
    typedef struct packed {
        logic             valid;
        logic             write;
        logic [SEC_W-1:0] sector;
        logic             tmatch;
        logic [WAY_W-1:0] way;
        logic             syn_ok;
        logic [SYN_W-1:0] syn;
        logic [ST_W-1:0]  st;
    } lk_stage_t;

    function automatic logic st_is_valid(input logic [1:0] code);
        line_state_e s;
        s = line_state_e'(code);
        return s != LS_INVALID;
    endfunction

    function automatic logic st_is_excl(input logic [1:0] code);
        line_state_e s;
        s = line_state_e'(code);
        return s == LS_EXCL;
    endfunction

    function automatic logic [DPOS_W-1:0] dirty_pos(input logic [WAY_W-1:0] way,
                                                     input logic [SEC_W-1:0] sec);
        return {way, sec};
    endfunction

endpackage

// File: rtl/l2tag_way_cmp.sv
module l2tag_way_cmp
    import l2tag_pkg::*;
(
    input  way_rec_t         rec,
    input  logic [TAG_W-1:0] tag,
    output logic             match
);
    // An invalid record never matches, whatever its tag bits hold
    assign match = st_is_valid(rec.st[1:0]) && (rec.tag == tag);
endmodule

// File: rtl/l2tag_way_enc.sv
module l2tag_way_enc
    import l2tag_pkg::*;
(
    input  logic [WAYS-1:0]  match,
    output logic             any,
    output logic [WAY_W-1:0] way
);
    // Lowest-numbered matching way wins
    always_comb begin
        any = |match;
        way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/l2tag_dirty_store.sv
module l2tag_dirty_store
    import l2tag_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IDX_W-1:0]   lk_idx,
    input  logic [DPOS_W-1:0]  lk_pos,
    output logic               lk_bit,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic [WAY_W-1:0]   rd_way,
    output logic [SECTORS-1:0] rd_nib,
    input  logic               set_en,
    input  logic [IDX_W-1:0]   set_idx,
    input  logic [DPOS_W-1:0]  set_pos,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    input  logic [WAY_W-1:0]   clr_way
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DIRTY_W-1:0] arr [DEPTH];
    logic               pend_v;
    logic [IDX_W-1:0]   pend_idx;
    logic [DPOS_W-1:0]  pend_pos;
    logic [DIRTY_W-1:0] pend_mask;
    logic [DIRTY_W-1:0] lk_row;
    logic [DIRTY_W-1:0] rd_row;

    assign pend_mask = DIRTY_W'(1) << pend_pos;

    // A set decided this cycle is held one clock, then committed
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v   <= 1'b0;
            pend_idx <= '0;
            pend_pos <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                arr[i] <= '0;
            end
        end else begin
            pend_v   <= set_en;
            pend_idx <= set_idx;
            pend_pos <= set_pos;
            if (pend_v) begin
                arr[pend_idx][pend_pos] <= 1'b1;
            end
            if (clr_en) begin
                arr[clr_idx][{clr_way, SEC_W'(0)} +: SECTORS] <= '0;
            end
        end
    end

    // Forward the pending set into both read paths
    always_comb begin
        lk_row = arr[lk_idx];
        rd_row = arr[rd_idx];
        if (pend_v && pend_idx == lk_idx) begin
            lk_row = lk_row | pend_mask;
        end
        if (pend_v && pend_idx == rd_idx) begin
            rd_row = rd_row | pend_mask;
        end
    end

    assign lk_bit = lk_row[lk_pos];
    assign rd_nib = rd_row[{rd_way, SEC_W'(0)} +: SECTORS];
endmodule

// File: rtl/l2_tag_bank.sv
module l2_tag_bank
    import l2tag_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               lk_valid,
    input  logic               lk_write,
    input  logic [IDX_W-1:0]   lk_index,
    input  logic [SEC_W-1:0]   lk_sector,
    input  logic [TAG_W-1:0]   lk_tag,
    input  logic [SYN_W-1:0]   lk_syn,
    output logic               rs_valid,
    output logic               rs_tag_match,
    output logic               rs_hit,
    output logic [WAY_W-1:0]   rs_way,
    output logic [SYN_W-1:0]   rs_syn,
    output logic [ST_W-1:0]    rs_state,
    output logic               rs_dirty,
    output logic               rs_wb_req,
    input  logic               cc_wr_en,
    input  logic               cc_wr_sel,
    input  logic               cc_rd_en,
    input  logic [IDX_W-1:0]   cc_index,
    input  logic [WAY_W-1:0]   cc_way,
    input  logic [TAG_W-1:0]   cc_bus,
    output logic               cc_rd_valid,
    output logic [REC_W-1:0]   cc_rd_rec,
    output logic [SECTORS-1:0] cc_rd_dirty
);
    localparam int DEPTH = 1 << IDX_W;

    way_rec_t tarr [DEPTH][WAYS];

    // ---------------- stage 0: compare ----------------
    way_rec_t         row0 [WAYS];
    logic [WAYS-1:0]  match_vec;
    logic             any0;
    logic [WAY_W-1:0] way0;
    way_rec_t         sel_rec;

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign row0[g] = tarr[lk_index][g];
        l2tag_way_cmp u_cmp (
            .rec  (row0[g]),
            .tag  (lk_tag),
            .match(match_vec[g])
        );
    end

    l2tag_way_enc u_enc (
        .match(match_vec),
        .any  (any0),
        .way  (way0)
    );

    assign sel_rec = any0 ? row0[way0] : '0;

    // ---------------- tag array: controller writes ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                for (int w = 0; w < WAYS; w++) begin
                    tarr[i][w] <= '0;
                end
            end
        end else if (cc_wr_en) begin
            if (!cc_wr_sel) begin
                tarr[cc_index][cc_way].tag <= cc_bus;
            end else begin
                tarr[cc_index][cc_way].syn <= cc_bus[ST_W +: SYN_W];
                tarr[cc_index][cc_way].st  <= cc_bus[ST_W-1:0];
            end
        end
    end

    // ---------------- stage 1: dirty lookup ----------------
    lk_stage_t        s1;
    logic [IDX_W-1:0] s1_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1     <= '0;
            s1_idx <= '0;
        end else begin
            s1.valid  <= lk_valid;
            s1.write  <= lk_write;
            s1.sector <= lk_sector;
            s1.tmatch <= any0;
            s1.way    <= way0;
            s1.syn_ok <= (sel_rec.syn == lk_syn);
            s1.syn    <= sel_rec.syn;
            s1.st     <= sel_rec.st;
            s1_idx    <= lk_index;
        end
    end

    logic               s1_dbit;
    logic               s1_hit;
    logic               set_en;
    logic [SECTORS-1:0] rd_nib;

    assign s1_hit = s1.valid && s1.tmatch && s1.syn_ok;
    assign set_en = s1_hit && s1.write && st_is_excl(s1.st[1:0]) && !s1_dbit;

    l2tag_dirty_store #(.IDX_W(IDX_W)) u_dirty (
        .clk    (clk),
        .rst    (rst),
        .lk_idx (s1_idx),
        .lk_pos (dirty_pos(s1.way, s1.sector)),
        .lk_bit (s1_dbit),
        .rd_idx (cc_index),
        .rd_way (cc_way),
        .rd_nib (rd_nib),
        .set_en (set_en),
        .set_idx(s1_idx),
        .set_pos(dirty_pos(s1.way, s1.sector)),
        .clr_en (cc_wr_en && cc_wr_sel),
        .clr_idx(cc_index),
        .clr_way(cc_way)
    );

    assign rs_valid     = s1.valid;
    assign rs_tag_match = s1.valid && s1.tmatch;
    assign rs_hit       = s1_hit;
    assign rs_way       = s1.way;
    assign rs_syn       = s1.syn;
    assign rs_state     = s1.st;
    assign rs_dirty     = s1_hit && s1_dbit;
    assign rs_wb_req    = s1_hit && s1.write && s1_dbit;

    // ---------------- controller read ----------------
    way_rec_t rd_rec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cc_rd_valid <= 1'b0;
            rd_rec_q    <= '0;
            cc_rd_dirty <= '0;
        end else begin
            cc_rd_valid <= cc_rd_en;
            if (cc_rd_en) begin
                rd_rec_q    <= tarr[cc_index][cc_way];
                cc_rd_dirty <= rd_nib;
            end
        end
    end

    assign cc_rd_rec = rd_rec_q;
endmodule

// File: rtl/l2_tag_bank_chk.sv
module l2_tag_bank_chk (
    input logic       clk,
    input logic       rst,
    input logic       lk_valid,
    input logic       cc_rd_en,
    input logic       rs_valid,
    input logic       rs_tag_match,
    input logic       rs_hit,
    input logic [1:0] rs_state_lo,
    input logic       rs_dirty,
    input logic       rs_wb_req,
    input logic       cc_rd_valid
);
    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rs_valid);                                   // R2
    AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rs_valid);                                 // R2
    AST_INVALID_NO_MATCH: assert property (@(posedge clk) disable iff (rst)
        rs_tag_match |-> rs_state_lo != 2'b00);                   // R3
    AST_HIT_NEEDS_TAG: assert property (@(posedge clk) disable iff (rst)
        rs_hit |-> rs_tag_match);                                 // R4
    AST_DIRTY_ONLY_EXCL: assert property (@(posedge clk) disable iff (rst)
        rs_dirty |-> rs_state_lo == 2'b10);                       // R6
    AST_WB_ON_DIRTY_HIT: assert property (@(posedge clk) disable iff (rst)
        rs_wb_req |-> rs_hit && rs_dirty);                        // R7
    AST_READ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        cc_rd_en |=> cc_rd_valid);                                // R10
endmodule

bind l2_tag_bank l2_tag_bank_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .lk_valid    (lk_valid),
    .cc_rd_en    (cc_rd_en),
    .rs_valid    (rs_valid),
    .rs_tag_match(rs_tag_match),
    .rs_hit      (rs_hit),
    .rs_state_lo (rs_state[1:0]),
    .rs_dirty    (rs_dirty),
    .rs_wb_req   (rs_wb_req),
    .cc_rd_valid (cc_rd_valid)
);

// File: tb/l2_tag_bank_tb.sv
module l2_tag_bank_tb;
    localparam int IDX_W = 8;
    localparam int NSET  = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst;
    always #10 clk = ~clk;

    logic             lk_valid, lk_write;
    logic [IDX_W-1:0] lk_index;
    logic [1:0]       lk_sector;
    logic [19:0]      lk_tag;
    logic [3:0]       lk_syn;
    logic             rs_valid, rs_tag_match, rs_hit, rs_dirty, rs_wb_req;
    logic [1:0]       rs_way;
    logic [3:0]       rs_syn;
    logic [7:0]       rs_state;
    logic             cc_wr_en, cc_wr_sel, cc_rd_en;
    logic [IDX_W-1:0] cc_index;
    logic [1:0]       cc_way;
    logic [19:0]      cc_bus;
    logic             cc_rd_valid;
    logic [31:0]      cc_rd_rec;
    logic [3:0]       cc_rd_dirty;

    l2_tag_bank #(.IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_write(lk_write), .lk_index(lk_index),
        .lk_sector(lk_sector), .lk_tag(lk_tag), .lk_syn(lk_syn),
        .rs_valid(rs_valid), .rs_tag_match(rs_tag_match), .rs_hit(rs_hit),
        .rs_way(rs_way), .rs_syn(rs_syn), .rs_state(rs_state),
        .rs_dirty(rs_dirty), .rs_wb_req(rs_wb_req),
        .cc_wr_en(cc_wr_en), .cc_wr_sel(cc_wr_sel), .cc_rd_en(cc_rd_en),
        .cc_index(cc_index), .cc_way(cc_way), .cc_bus(cc_bus),
        .cc_rd_valid(cc_rd_valid), .cc_rd_rec(cc_rd_rec), .cc_rd_dirty(cc_rd_dirty)
    );

    int checks = 0;
    int errors = 0;

    // reference model of the bank contents
    logic [19:0] m_tag [NSET][4];
    logic [3:0]  m_syn [NSET][4];
    logic [7:0]  m_st  [NSET][4];
    logic [15:0] m_dirty [NSET];

    // scoreboard queues
    logic [17:0] lk_exp_q [$];
    string       lk_req_q [$];
    logic [35:0] rd_exp_q [$];
    string       rd_req_q [$];

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        lk_valid = 1'b0; lk_write = 1'b0; lk_index = '0; lk_sector = '0;
        lk_tag = '0; lk_syn = '0;
        cc_wr_en = 1'b0; cc_wr_sel = 1'b0; cc_rd_en = 1'b0;
        cc_index = '0; cc_way = '0; cc_bus = '0;
    endtask

    task automatic gap();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic cc_write(input int idx, input int way, input bit sel, input logic [19:0] bus);
        @(negedge clk);
        idle_inputs();
        cc_wr_en = 1'b1; cc_wr_sel = sel;
        cc_index = IDX_W'(idx); cc_way = 2'(way); cc_bus = bus;
        if (!sel) begin
            m_tag[idx][way] = bus;
        end else begin
            m_syn[idx][way] = bus[11:8];
            m_st[idx][way]  = bus[7:0];
            m_dirty[idx][way*4 +: 4] = 4'b0000;
        end
    endtask

    task automatic lookup(input int idx, input int sec, input logic [19:0] tag,
                          input logic [3:0] syn, input bit wr, input string req);
        bit         tm, hit, dbit;
        int         way;
        logic [3:0] esyn;
        logic [7:0] est;
        @(negedge clk);
        idle_inputs();
        lk_valid = 1'b1; lk_write = wr; lk_index = IDX_W'(idx);
        lk_sector = 2'(sec); lk_tag = tag; lk_syn = syn;
        tm = 1'b0; way = 0;
        for (int w = 0; w < 4; w++) begin
            if (!tm && m_st[idx][w][1:0] != 2'b00 && m_tag[idx][w] == tag) begin
                tm = 1'b1; way = w;
            end
        end
        esyn = tm ? m_syn[idx][way] : 4'h0;
        est  = tm ? m_st[idx][way] : 8'h00;
        hit  = tm && (esyn == syn);
        dbit = m_dirty[idx][way*4 + sec];
        lk_exp_q.push_back({tm, hit, 2'(way), esyn, est, hit && dbit, hit && wr && dbit});
        lk_req_q.push_back(req);
        if (hit && wr && est[1:0] == 2'b10 && !dbit) begin
            m_dirty[idx][way*4 + sec] = 1'b1;
        end
    endtask

    task automatic cc_read(input int idx, input int way, input string req);
        @(negedge clk);
        idle_inputs();
        cc_rd_en = 1'b1; cc_index = IDX_W'(idx); cc_way = 2'(way);
        rd_exp_q.push_back({m_tag[idx][way], m_syn[idx][way], m_st[idx][way],
                            m_dirty[idx][way*4 +: 4]});
        rd_req_q.push_back(req);
    endtask

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (!rst) begin
            if (rs_valid) begin
                if (lk_exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R2 unexpected result actual=1 expected=0");
                end else begin
                    check(lk_req_q.pop_front(),
                          64'({rs_tag_match, rs_hit, rs_way, rs_syn, rs_state, rs_dirty, rs_wb_req}),
                          64'(lk_exp_q.pop_front()));
                end
            end
            if (cc_rd_valid) begin
                if (rd_exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R10 unexpected read data actual=1 expected=0");
                end else begin
                    check(rd_req_q.pop_front(), 64'({cc_rd_rec, cc_rd_dirty}),
                          64'(rd_exp_q.pop_front()));
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NSET; i++) begin
            m_dirty[i] = '0;
            for (int w = 0; w < 4; w++) begin
                m_tag[i][w] = '0; m_syn[i][w] = '0; m_st[i][w] = '0;
            end
        end
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", 64'({rs_valid, cc_rd_valid}), 64'(0));
        rst = 1'b0;

        // R1: empty bank misses
        lookup(5, 0, 20'hABCDE, 4'h3, 1'b0, "R1");
        // build set 5 way 2: exclusive, synonym 3
        cc_write(5, 2, 1'b0, 20'hABCDE);
        cc_write(5, 2, 1'b1, {8'h00, 4'h3, 8'h02});
        lookup(5, 0, 20'hABCDE, 4'h3, 1'b0, "R2");
        lookup(5, 0, 20'hABCDE, 4'h4, 1'b0, "R4");
        // R3: equal tag on invalid way 1 is ignored; invalid set misses
        cc_write(5, 1, 1'b0, 20'hABCDE);
        lookup(5, 0, 20'hABCDE, 4'h3, 1'b0, "R3");
        cc_write(6, 0, 1'b0, 20'h55555);
        lookup(6, 0, 20'h55555, 4'h0, 1'b0, "R3");
        // R4: synonym mismatch write sets nothing
        lookup(5, 1, 20'hABCDE, 4'h4, 1'b1, "R4");
        // R5 / R8 / R7 sequence on sector 1
        lookup(5, 1, 20'hABCDE, 4'h3, 1'b1, "R5");
        lookup(5, 1, 20'hABCDE, 4'h3, 1'b1, "R8");
        lookup(5, 1, 20'hABCDE, 4'h3, 1'b0, "R7");
        lookup(5, 2, 20'hABCDE, 4'h3, 1'b0, "R5");
        gap();
        cc_read(5, 2, "R10");
        lookup(5, 1, 20'hABCDE, 4'h3, 1'b1, "R7");
        // R6: shared line never turns dirty
        cc_write(7, 0, 1'b0, 20'h0F0F0);
        cc_write(7, 0, 1'b1, {8'h00, 4'h1, 8'h01});
        lookup(7, 3, 20'h0F0F0, 4'h1, 1'b1, "R6");
        lookup(7, 3, 20'h0F0F0, 4'h1, 1'b0, "R6");
        gap();
        cc_read(7, 0, "R6");
        // R11: two valid ways share a tag
        cc_write(9, 0, 1'b0, 20'h12121);
        cc_write(9, 0, 1'b1, {8'h00, 4'h0, 8'h02});
        cc_write(9, 1, 1'b0, 20'h77777);
        cc_write(9, 1, 1'b1, {8'h00, 4'h0, 8'h02});
        cc_write(9, 3, 1'b0, 20'h77777);
        cc_write(9, 3, 1'b1, {8'h00, 4'h0, 8'h02});
        lookup(9, 0, 20'h77777, 4'h0, 1'b0, "R11");
        // R12: reads leave dirty bits untouched
        lookup(9, 2, 20'h77777, 4'h0, 1'b0, "R12");
        lookup(9, 2, 20'h77777, 4'h0, 1'b0, "R12");
        gap();
        cc_read(9, 1, "R12");
        // R9: state write clears dirty, tag write keeps state
        cc_write(5, 2, 1'b1, {8'h00, 4'h6, 8'hC2});
        gap();
        cc_read(5, 2, "R9");
        cc_write(5, 2, 1'b0, 20'h13579);
        gap();
        cc_read(5, 2, "R9");
        lookup(5, 1, 20'h13579, 4'h6, 1'b0, "R9");
        lookup(5, 1, 20'hABCDE, 4'h3, 1'b0, "R9");

        repeat (4) gap();
        check("R2", 64'(lk_exp_q.size() + rd_exp_q.size()), 64'(0));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule